// File: doc/BRIEF.md
# Write-One-to-Clear Interrupt Aggregator

This block gathers single-cycle event pulses from the parts of a PCI host bridge and turns them into one level-sensitive interrupt. Each pulse sets a sticky bit in a status word. Software clears a bit by writing a one to it. A per-bit mask register chooses which latched bits may raise the interrupt. A single global enable bit gates the interrupt output as a whole.

The status word is sparse. Only these bits exist:
- bits 0 to 3: inbound descriptor done, OK, error and end-of-list.
- bits 4 to 7: the same four flags for the outbound direction.
- bit 9: inbound out-of-descriptors.
- bit 25: external device interrupt line.
- bit 26: bus abort.

All other bits are tied to zero.

The block also reports the index of the lowest-numbered pending, unmasked bit, with a valid flag. An interrupt handler can read that index and service sources in ascending order without scanning the word itself. Register access uses a single-cycle port: writes take effect at the clock edge, and read data is combinational from the address.

Top module: `irq_agg`

## Requirements
- R1: After reset, the status, mask and enable registers all read 0, `irq_o` is low and `pend_vld_o` is low.
- R2: A pulse on `evt_i[b]`, where b is an implemented bit (0 to 7, 9, 25, 26), sets status bit b at the next clock edge. The bit stays set until software clears it.
- R3: A write to the status register (offset 0x500) clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Unimplemented bits (all except 0 to 7, 9, 25, 26) read 0 in both the status and the mask register, whatever is pulsed or written.
- R6: The mask register (offset 0x504) holds the written value on its implemented bits. The enable register (offset 0x508) keeps only write-data bit 0 and reads it back in bit 0.
- R7: `irq_o` is high exactly when enable bit 0 is 1 and at least one status bit is set with its mask bit also set.
- R8: `pend_idx_o` gives the lowest bit number set in (status AND mask). `pend_vld_o` is high exactly when that set is non-empty. Neither depends on the enable bit.
- R9: A masked status bit stays latched and readable, but it affects neither `irq_o` nor `pend_idx_o`.
- R10: A read of any offset other than 0x500, 0x504 or 0x508 returns 0. A write to any such offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| evt_i | input | 32 | Event pulse lines, one per status bit |
| irq_o | output | 1 | Level interrupt output |
| pend_idx_o | output | 5 | Lowest pending unmasked source number |
| pend_vld_o | output | 1 | High when `pend_idx_o` names a real source |

## Verification
A hardware event pulse and a software clear of the status word can land in the same clock cycle. The block must then keep the event, so that no interrupt is lost. The bench provokes this by pulsing some status bits while a clearing write of all ones is applied in that same cycle. It then reads the status back: the pulsed bits must still be set and every other bit must be cleared. It also checks that the lowest-pending index points at the surviving bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h508;

  // bits 0-7 descriptor flags, 9 out-of-descriptors, 25 external line, 26 abort
  localparam logic [DATA_W-1:0] SRC_IMPL = 32'h0600_02FF;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned     AW      = ADDR_W,
  parameter logic [AW-1:0]   A_STS   = OFS_STATUS,
  parameter logic [AW-1:0]   A_MSK   = OFS_MASK,
  parameter logic [AW-1:0]   A_EN    = OFS_ENABLE
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);
  always_comb begin
    if (addr_i == A_STS)      sel_o = SEL_STATUS;
    else if (addr_i == A_MSK) sel_o = SEL_MASK;
    else if (addr_i == A_EN)  sel_o = SEL_ENABLE;
    else                      sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int unsigned       DW   = 32,
  parameter logic [DW-1:0]     IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_i,
  input  logic [DW-1:0] clr_bits_i,
  output logic [DW-1:0] sts_o
);
  logic [DW-1:0] sts_q;
  logic [DW-1:0] sts_d;
  logic          sts_ce;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      // a new event outranks a clear of the same bit
      assign sts_d[b] = evt_i[b] | (sts_q[b] & ~(clr_i & clr_bits_i[b]));
    end else begin : g_tied
      assign sts_d[b] = 1'b0;
    end
  end

  assign sts_ce = clr_i | (|(evt_i & IMPL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl #(
  parameter int unsigned   DW   = 32,
  parameter logic [DW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msk_wr_i,
  input  logic          en_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] msk_o,
  output logic          en_o
);
  logic [DW-1:0] msk_q, msk_d;
  logic          en_q, en_d;

  always_comb begin
    msk_d = wdata_i & IMPL;
    en_d  = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        msk_q <= '0;
    else if (msk_wr_i) msk_q <= msk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (en_wr_i) en_q <= en_d;
  end

  assign msk_o = msk_q;
  assign en_o  = en_q;
endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio #(
  parameter int unsigned DW = 32,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic [DW-1:0] pend_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = |pend_i;
    for (int i = DW - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned   DW    = DATA_W,
  parameter int unsigned   AW    = ADDR_W,
  parameter logic [DW-1:0] IMPL  = SRC_IMPL,
  parameter logic [AW-1:0] A_STS = OFS_STATUS,
  parameter logic [AW-1:0] A_MSK = OFS_MASK,
  parameter logic [AW-1:0] A_EN  = OFS_ENABLE,
  localparam int unsigned  IW    = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] evt_i,
  output logic          irq_o,
  output logic [IW-1:0] pend_idx_o,
  output logic          pend_vld_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  reg_sel_e      sel;
  logic [DW-1:0] sts_q;
  logic [DW-1:0] msk_q;
  logic          en_q;
  logic [DW-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  irq_agg_decode #(.AW(AW), .A_STS(A_STS), .A_MSK(A_MSK), .A_EN(A_EN)) u_dec (
    .addr_i (reg_addr_i),
    .sel_o  (sel)
  );

  irq_agg_status #(.DW(DW), .IMPL(IMPL)) u_sts (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .evt_i      (evt_i),
    .clr_i      (reg_wr_i && sel == SEL_STATUS),
    .clr_bits_i (reg_wdata_i),
    .sts_o      (sts_q)
  );

  irq_agg_ctrl #(.DW(DW), .IMPL(IMPL)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .msk_wr_i (reg_wr_i && sel == SEL_MASK),
    .en_wr_i  (reg_wr_i && sel == SEL_ENABLE),
    .wdata_i  (reg_wdata_i),
    .msk_o    (msk_q),
    .en_o     (en_q)
  );

  assign pend = sts_q & msk_q;

  irq_agg_prio #(.DW(DW)) u_prio (
    .pend_i (pend),
    .idx_o  (pend_idx_o),
    .vld_o  (pend_vld_o)
  );

  assign irq_o = en_q & pend_vld_o;

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata_o = sts_q;
      SEL_MASK:   reg_rdata_o = msk_q;
      SEL_ENABLE: reg_rdata_o = {{(DW-1){1'b0}}, en_q};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned   DW    = 32,
  parameter int unsigned   AW    = 12,
  parameter logic [DW-1:0] IMPL  = '1,
  parameter logic [AW-1:0] A_STS = '0,
  localparam int unsigned  IW    = $clog2(DW)
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] evt_i,
  input logic [DW-1:0] sts_q,
  input logic [DW-1:0] msk_q,
  input logic          en_q,
  input logic          irq_o,
  input logic [IW-1:0] pend_idx_o,
  input logic          pend_vld_o
);
  // R2 R4
  evt_latched_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(evt_i & IMPL)) |=> ((sts_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_i && reg_addr_i == A_STS && !(|(evt_i & IMPL)))
      |=> (sts_q == ($past(sts_q) & ~$past(reg_wdata_i))));

  // R5
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((sts_q & ~IMPL) == '0) && ((msk_q & ~IMPL) == '0));

  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (pend_vld_o && en_q));

  // R7
  irq_when_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_vld_o && en_q) |-> irq_o);

  // R8 R9
  idx_points_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_vld_o |-> (sts_q[pend_idx_o] && msk_q[pend_idx_o]));

  // R8
  idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_vld_o |-> ((sts_q & msk_q & ((DW'(1) << pend_idx_o) - DW'(1))) == '0));

  // R8
  vld_empty_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((sts_q & msk_q) == '0) |-> !pend_vld_o);
endmodule

bind irq_agg irq_agg_chk #(
  .DW(DW), .AW(AW), .IMPL(IMPL), .A_STS(A_STS)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .evt_i       (evt_i),
  .sts_q       (sts_q),
  .msk_q       (msk_q),
  .en_q        (en_q),
  .irq_o       (irq_o),
  .pend_idx_o  (pend_idx_o),
  .pend_vld_o  (pend_vld_o)
);

// File: tb/irq_agg_bench.sv
module irq_agg_bench;
  logic        clk;
  logic        rst_n;
  logic        reg_wr_i;
  logic [11:0] reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [31:0] evt_i;
  logic        irq_o;
  logic [4:0]  pend_idx_o;
  logic        pend_vld_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_agg u_irq_agg (
    .clk, .rst_n, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .evt_i, .irq_o, .pend_idx_o, .pend_vld_o
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] evt;
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp_sts;
    logic        exp_irq;
    logic        exp_vld;
    logic [4:0]  exp_idx;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{32'h0,         1'b1, 12'h504, 32'h0600_02FF, 32'h0,         1'b0, 1'b0, 5'd0},
    '{32'h0,         1'b1, 12'h508, 32'h1,         32'h0,         1'b0, 1'b0, 5'd0},
    '{32'h0400_0000, 1'b0, 12'h000, 32'h0,         32'h0400_0000, 1'b1, 1'b1, 5'd26},
    '{32'h0000_0208, 1'b0, 12'h000, 32'h0,         32'h0400_0208, 1'b1, 1'b1, 5'd3},
    '{32'h0,         1'b1, 12'h500, 32'h8,         32'h0400_0200, 1'b1, 1'b1, 5'd9},
    '{32'h0,         1'b1, 12'h500, 32'h0,         32'h0400_0200, 1'b1, 1'b1, 5'd9},
    '{32'h0,         1'b1, 12'h500, 32'h0400_0200, 32'h0,         1'b0, 1'b0, 5'd0},
    '{32'h0200_0000, 1'b0, 12'h000, 32'h0,         32'h0200_0000, 1'b1, 1'b1, 5'd25},
    '{32'h0,         1'b1, 12'h504, 32'h0000_00FF, 32'h0200_0000, 1'b0, 1'b0, 5'd0},
    '{32'h0000_0010, 1'b0, 12'h000, 32'h0,         32'h0200_0010, 1'b1, 1'b1, 5'd4},
    '{32'h0,         1'b1, 12'h508, 32'h0,         32'h0200_0010, 1'b0, 1'b1, 5'd4},
    '{32'h0,         1'b1, 12'h508, 32'h1,         32'h0200_0010, 1'b1, 1'b1, 5'd4},
    '{32'h0000_0800, 1'b0, 12'h000, 32'h0,         32'h0200_0010, 1'b1, 1'b1, 5'd4},
    '{32'h0000_0010, 1'b1, 12'h500, 32'hFFFF_FFFF, 32'h0000_0010, 1'b1, 1'b1, 5'd4},
    '{32'h0,         1'b1, 12'h500, 32'h0000_0010, 32'h0,         1'b0, 1'b0, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] e, input logic w,
                     input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    evt_i = e; reg_wr_i = w; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h500, v); chk("R1 status", v, 32'h0);
    rd(12'h504, v); chk("R1 mask", v, 32'h0);
    rd(12'h508, v); chk("R1 enable", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 vld", {31'b0, pend_vld_o}, 32'h0);

    // table: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].evt, TBL[i].wr, TBL[i].addr, TBL[i].wdata);
      rd(12'h500, v);
      chk($sformatf("R2/R3/R4/R5 status row %0d", i), v, TBL[i].exp_sts);
      chk($sformatf("R7 irq row %0d", i), {31'b0, irq_o}, {31'b0, TBL[i].exp_irq});
      chk($sformatf("R8 vld row %0d", i), {31'b0, pend_vld_o}, {31'b0, TBL[i].exp_vld});
      if (TBL[i].exp_vld)
        chk($sformatf("R8 R9 idx row %0d", i), {27'b0, pend_idx_o}, {27'b0, TBL[i].exp_idx});
    end

    // R6 mask and enable readback with only implemented bits kept
    cyc(32'h0, 1'b1, 12'h504, 32'hFFFF_FFFF);
    rd(12'h504, v); chk("R6 R5 mask readback", v, 32'h0600_02FF);
    cyc(32'h0, 1'b1, 12'h508, 32'hFFFF_FFFE);
    rd(12'h508, v); chk("R6 enable bit0 only", v, 32'h0);
    cyc(32'h0, 1'b1, 12'h508, 32'hFFFF_FFFF);
    rd(12'h508, v); chk("R6 enable readback", v, 32'h1);

    // R5 unimplemented events never latch
    cyc(32'hF9FF_FD00, 1'b0, 12'h000, 32'h0);
    rd(12'h500, v); chk("R5 unimpl status", v, 32'h0);
    chk("R5 irq stays low", {31'b0, irq_o}, 32'h0);

    // R8 all sources together -> lowest first
    cyc(32'hFFFF_FFFF, 1'b0, 12'h000, 32'h0);
    rd(12'h500, v); chk("R2 all sources", v, 32'h0600_02FF);
    chk("R8 lowest of all", {27'b0, pend_idx_o}, 32'd0);

    // R10 unmapped offsets
    cyc(32'h0, 1'b1, 12'h50C, 32'hFFFF_FFFF);
    cyc(32'h0, 1'b1, 12'h100, 32'hFFFF_FFFF);
    rd(12'h50C, v); chk("R10 unmapped read", v, 32'h0);
    rd(12'h500, v); chk("R10 status untouched", v, 32'h0600_02FF);
    rd(12'h504, v); chk("R10 mask untouched", v, 32'h0600_02FF);
    rd(12'h508, v); chk("R10 enable untouched", v, 32'h1);

    // R1 reset in the middle of operation
    @(negedge clk); rst_n = 1'b0; #1;
    rd(12'h500, v); chk("R1 mid reset status", v, 32'h0);
    rd(12'h504, v); chk("R1 mid reset mask", v, 32'h0);
    chk("R1 mid reset irq", {31'b0, irq_o}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule